// File: doc/BRIEF.md
# Oscillator Trim-Correction Control Register

This block is an 8-bit control and status register that sequences an on-chip oscillator frequency-correction engine. Software writes the register over a byte-wide port and reads its state back. The register holds a run bit that starts the engine, a mode bit that selects continuous or one-shot operation, and an interrupt-enable bit. The engine reports each finished correction with a single-cycle completion pulse. The block does not model the measurement or the trim arithmetic.

In continuous mode the run bit stays set until software clears it. In one-shot (interval) mode the hardware clears the run bit when the completion pulse arrives. A hardware clear takes priority over a software set in the same cycle. The mode bit cannot be changed while a run is in progress. After software stops the engine, a restart is refused for a short window. A completion with the enable set produces a one-cycle interrupt pulse.

Top module: `trimCorrCtl`

## Requirements
- R1: After reset the read value is 0x00, and runOut, modeOut and irqOut are all low.
- R2: Field layout: bit 7 is the mode (0 continuous, 1 interval), bit 6 is the interrupt enable, and bit 0 is the run bit. The mode and the enable read back as written, subject to R7.
- R3: Bits 5 to 1 always read 0, whatever value is written to them.
- R4: In continuous mode a completion pulse leaves the run bit at 1. Only a software write of 0 clears it.
- R5: In interval mode a completion pulse while running clears the run bit at the same clock edge, so the bit reads 0 in the following cycle.
- R6: A completion pulse seen while running with the enable at 1 drives irqOut high for exactly one cycle, in the cycle after the pulse. With the enable at 0, irqOut stays low.
- R7: A write while the run bit is 1 leaves the mode bit unchanged.
- R8: A software write of 1 to the run bit in the same cycle as a hardware clear leaves the run bit at 0.
- R9: After a write with bit 0 at 0, writes of 1 to bit 0 in the next 2 cycles are ignored. A write in the third cycle is accepted.
- R10: A completion pulse while the run bit is 0 changes no bit and raises no interrupt.
- R11: A write made while stopped that sets the run bit and changes the mode applies the new mode, so the run proceeds in that mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Current register value |
| doneIn | input | 1 | One-cycle completion pulse from the correction engine |
| runOut | output | 1 | Run request to the engine (run bit) |
| modeOut | output | 1 | Mode to the engine, 1 = interval |
| irqOut | output | 1 | Completion interrupt pulse |

## Verification
Every result is registered once. A write or a completion pulse presented before a clock edge shows up on rdData, runOut, modeOut and irqOut in the cycle after that edge. The restart lockout covers the 2 edges that follow the edge that takes the stopping write. The bench drives inputs on the falling edge. Its reference model advances on each rising edge from the inputs held there, and it compares all outputs 1 ns after that edge, so every comparison sees exactly one edge's worth of change. Directed runs cover each corner (a set that races a clear, restart attempts at lockout offsets 1, 2 and 3, and completions while stopped). A long random run follows to mix these cases.

// File: rtl/trimPkg.sv
package trimPkg;
  localparam int REG_W    = 8;
  localparam int MODE_BIT = 7;
  localparam int IE_BIT   = 6;
  localparam int RUN_BIT  = 0;

  typedef struct packed {
    logic setRun;
    logic clrRun;
    logic loadMode;
    logic loadIe;
    logic fireIrq;
  } ctlStrb_t;
endpackage

// File: rtl/trimCtl.sv
module trimCtl
  import trimPkg::*;
#(
  parameter int LOCK_CYCLES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrEn,
  input  logic     wrRun,
  input  logic     doneIn,
  input  logic     runBit,
  input  logic     modeBit,
  input  logic     ieBit,
  output ctlStrb_t strb
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOCK_LOAD = CNT_W'(LOCK_CYCLES);

  logic [CNT_W-1:0] lockCnt;
  logic             swStop;
  logic             hwClr;
  logic             validDone;

  assign validDone = doneIn && runBit;
  assign hwClr     = validDone && modeBit;
  assign swStop    = wrEn && !wrRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lockCnt <= '0;
    else if (swStop)          lockCnt <= LOCK_LOAD;
    else if (lockCnt != '0)   lockCnt <= lockCnt - 1'b1;
  end

  always_comb begin
    strb          = '0;
    strb.clrRun   = hwClr || swStop;
    strb.setRun   = wrEn && wrRun && (lockCnt == '0) && !hwClr;
    strb.loadMode = wrEn && !runBit;
    strb.loadIe   = wrEn;
    strb.fireIrq  = validDone && ieBit;
  end

  // R8
  hw_clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    hwClr |-> !strb.setRun);

  // R10
  idle_done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneIn && !runBit) |-> !strb.fireIrq);
endmodule

// File: rtl/trimRegs.sv
module trimRegs
  import trimPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrb_t         strb,
  input  logic             wrMode,
  input  logic             wrIe,
  output logic             runBit,
  output logic             modeBit,
  output logic             ieBit,
  output logic             irqPulse,
  output logic [REG_W-1:0] rdData
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit   <= 1'b0;
      modeBit  <= 1'b0;
      ieBit    <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      if (strb.clrRun)      runBit <= 1'b0;
      else if (strb.setRun) runBit <= 1'b1;
      if (strb.loadMode)    modeBit <= wrMode;
      if (strb.loadIe)      ieBit <= wrIe;
      irqPulse <= strb.fireIrq;
    end
  end

  always_comb begin
    rdData           = '0;
    rdData[MODE_BIT] = modeBit;
    rdData[IE_BIT]   = ieBit;
    rdData[RUN_BIT]  = runBit;
  end

  // R7
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    runBit |=> $stable(modeBit));

  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse || $past(strb.fireIrq));
endmodule

// File: rtl/trimCorrCtl.sv
module trimCorrCtl
  import trimPkg::*;
#(
  parameter int LOCK_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             doneIn,
  output logic             runOut,
  output logic             modeOut,
  output logic             irqOut
);
  ctlStrb_t strb;
  logic     runBit, modeBit, ieBit;
  logic     unusedRsvd;

  assign unusedRsvd = ^wrData[MODE_BIT-2:RUN_BIT+1];

  trimCtl #(.LOCK_CYCLES(LOCK_CYCLES)) ctlU (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrRun(wrData[RUN_BIT]),
    .doneIn(doneIn), .runBit(runBit), .modeBit(modeBit), .ieBit(ieBit),
    .strb(strb)
  );

  trimRegs regsU (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrMode(wrData[MODE_BIT]), .wrIe(wrData[IE_BIT]),
    .runBit(runBit), .modeBit(modeBit), .ieBit(ieBit),
    .irqPulse(irqOut), .rdData(rdData)
  );

  assign runOut  = runBit;
  assign modeOut = modeBit;

  // R4
  cont_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runOut && !modeOut && !(wrEn && !wrData[RUN_BIT])) |=> runOut);

  // R5
  oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneIn && runOut && modeOut) |=> !runOut);

  // R6
  irq_due_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneIn && runOut && rdData[IE_BIT]) |=> irqOut);

  // R9
  stop_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[RUN_BIT]) |=> !runOut);

  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdData[MODE_BIT-2:RUN_BIT+1] == '0));
endmodule

// File: tb/trimCorrCtl_test.sv
`timescale 1ns/1ps
module trimCorrCtl_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       doneIn = 1'b0;
  logic [7:0] rdData;
  logic       runOut, modeOut, irqOut;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";
  bit modelOn = 0;

  // reference state
  int mRun = 0, mMode = 0, mIe = 0, mIrq = 0, mLock = 0;

  always #2.5 clk = ~clk;

  trimCorrCtl uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .doneIn(doneIn), .runOut(runOut), .modeOut(modeOut), .irqOut(irqOut)
  );

  task automatic cmp(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (modelOn) begin
      int fire, hwClr, wr0, wr1, nRun, nMode, nIe, nLock;
      fire  = (doneIn && mRun && mIe) ? 1 : 0;
      hwClr = (doneIn && mRun && mMode) ? 1 : 0;
      wr0   = (wrEn && !wrData[0]) ? 1 : 0;
      wr1   = (wrEn && wrData[0] && mLock == 0) ? 1 : 0;
      nMode = (wrEn && mRun == 0) ? int'(wrData[7]) : mMode;
      nIe   = wrEn ? int'(wrData[6]) : mIe;
      if (hwClr != 0 || wr0 != 0) nRun = 0;
      else if (wr1 != 0)          nRun = 1;
      else                        nRun = mRun;
      nLock = (wr0 != 0) ? 2 : ((mLock > 0) ? mLock - 1 : 0);
      mRun = nRun; mMode = nMode; mIe = nIe; mIrq = fire; mLock = nLock;
      #1;
      cmp(curReq, "rdData", int'(rdData), (mMode << 7) | (mIe << 6) | mRun);
      cmp(curReq, "runOut", int'(runOut), mRun);
      cmp(curReq, "modeOut", int'(modeOut), mMode);
      cmp(curReq, "irqOut", int'(irqOut), mIrq);
    end
  end

  task automatic step(input bit w, input logic [7:0] d, input bit dn);
    @(negedge clk);
    wrEn = w; wrData = d; doneIn = dn;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0);
  endtask

  // sample one edge later than the last step
  task automatic expectRd(string req, logic [7:0] exp, bit expIrq);
    @(posedge clk); #1.5;
    cmp(req, "rdData(direct)", int'(rdData), int'(exp));
    cmp(req, "irqOut(direct)", int'(irqOut), int'(expIrq));
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    cmp("R1", "rdData", int'(rdData), 0);
    cmp("R1", "outs", int'({runOut, modeOut, irqOut}), 0);
    rstN = 1'b1;
    modelOn = 1;

    // R2 / R3: fields and reserved bits
    curReq = "R2"; step(1, 8'hFE, 0); expectRd("R3", 8'hC0, 0);
    step(1, 8'h3E, 0); expectRd("R2", 8'h00, 0);
    idle(3);

    // R4 / R6: continuous with interrupts
    curReq = "R4"; step(1, 8'h41, 0); expectRd("R4", 8'h41, 0);
    step(0, 8'h00, 1); expectRd("R6", 8'h41, 1);
    step(0, 8'h00, 0); expectRd("R6", 8'h41, 0);
    step(0, 8'h00, 1); step(0, 8'h00, 1); idle(2);
    // R7: mode write while running ignored
    curReq = "R7"; step(1, 8'hC1, 0); expectRd("R7", 8'h41, 0);

    // R9: restart lockout
    curReq = "R9"; step(1, 8'h40, 0);
    step(1, 8'h41, 0); expectRd("R9", 8'h40, 0);
    step(1, 8'h41, 0); expectRd("R9", 8'h40, 0);
    step(1, 8'h41, 0); expectRd("R9", 8'h41, 0);
    step(1, 8'h00, 0); idle(3);

    // R11 + R5 + R6 disabled: interval, ie off
    curReq = "R11"; step(1, 8'h81, 0); expectRd("R11", 8'h81, 0);
    curReq = "R5"; step(0, 8'h00, 1); expectRd("R5", 8'h80, 0);
    idle(1);
    // R10: completion while stopped
    curReq = "R10"; step(0, 8'h00, 1); expectRd("R10", 8'h80, 0);
    idle(3);

    // R8: set races hardware clear
    curReq = "R8"; step(1, 8'hC1, 0); expectRd("R8", 8'hC1, 0);
    step(1, 8'hC1, 1); expectRd("R8", 8'hC0, 1);
    idle(2);
    step(1, 8'h01, 0); expectRd("R11", 8'h01, 0);
    step(1, 8'h00, 0); idle(3);

    // random mix across all rules
    curReq = "R2";
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      step(($urandom % 4) == 0, d, ($urandom % 5) == 0);
    end
    idle(2);
    modelOn = 0;
    finishRun();
  end
endmodule